// File: doc/BRIEF.md
# Dual-Channel Wiper Command Slave (two-wire serial)

This block is the serial front end of a two-channel digital trimmer. It listens on an I2C-compatible two-wire bus and accepts two kinds of transfer. A write carries an address byte, one instruction byte and then any number of data bytes. Each data byte is handed to the wiper logic as a single-cycle strobe, together with the fields of the instruction that was latched earlier in the same transfer. A write whose instruction has its program bit set also raises a request to the fuse sequencer along with each strobe. A read carries an address byte and is answered with the wiper code of the currently selected channel, then a status byte that holds the two validation bits. No register pointer is involved.

SCL and SDA are oversampled on a system clock that runs at least eight times faster than SCL. Each line passes through a synchroniser, and an edge detector finds START, STOP and the clock edges. The slave drives SDA only by pulling it low, through `sda_oe`. The control state machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_INSTR`, `ST_INSTR_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_TX`, `ST_TX_ACK` and `ST_SKIP`. START leads to `ST_ADDR` from any state, and STOP leads to `ST_IDLE` from any state. The transitions are as follows:
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK` goes to `ST_TX` when the R/W bit is 1 and to `ST_INSTR` when it is 0.
- `ST_INSTR` goes to `ST_INSTR_ACK` when the reserved bit is 0 and to `ST_SKIP` when it is 1.
- `ST_INSTR_ACK` goes to `ST_DATA`.
- `ST_DATA` and `ST_DATA_ACK` alternate.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX` when the master acknowledges and to `ST_SKIP` when it does not.

Top module: `potcmd_i2c_slave`

## Requirements
- R1: The 7-bit slave address is binary 01011 followed by two low bits. The low bits come from `addr_pins[1:0]` when parameter `USE_PINS` is 1 and are fixed at 11 otherwise. A matching address byte is acknowledged by pulling SDA low during the ninth clock, and no other address is acknowledged.
- R2: After an address mismatch, the slave ignores the rest of the transfer until the next START. It acknowledges no byte and produces no strobe.
- R3: The instruction byte is decoded as follows: bit 7 is the channel, bit 6 is shutdown, bit 5 is program, bit 4 must be 0, bit 3 is overwrite, and bits 2..0 are ignored. The channel, shutdown and overwrite fields appear on `wr_chan`, `wr_shdn` and `wr_ovr` with every strobe.
- R4: An instruction byte with bit 4 set is not acknowledged. The data bytes that follow it produce no strobe.
- R5: Every data byte after an accepted instruction produces exactly one single-cycle `wr_stb`, with `wr_code` equal to that byte. The latched instruction is reused for each of these bytes until STOP.
- R6: `prog_req` pulses in the same cycle as `wr_stb` when the program bit of the latched instruction is 1. It never pulses otherwise.
- R7: A read returns bytes MSB first. The first byte is the code of the selected channel. The second byte carries the validation bits in bits 7..6, and bits 5..0 read as 0. As long as the master acknowledges, further bytes alternate between the code byte and the status byte.
- R8: The selected channel is the one named by the last accepted instruction. An address and instruction with no data byte is enough to change it, and it resets to channel 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START or STOP.
- R10: A START at any point restarts the address phase, even in the middle of a byte. After a STOP, no byte is acknowledged until the next START.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: After reset, SDA is released, no strobe or request is active, and channel 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_pins | input | 2 | Address low bits when USE_PINS is 1 |
| chan_codes | input | 2x8 | Current wiper codes, index = channel |
| valid_bits | input | 2 | Programming validation bits for readback |
| wr_stb | output | 1 | One-cycle write strobe to the wiper block |
| wr_chan | output | 1 | Channel of the latched instruction |
| wr_shdn | output | 1 | Shutdown field of the latched instruction |
| wr_ovr | output | 1 | Overwrite field of the latched instruction |
| wr_code | output | 8 | Data byte carried by the strobe |
| prog_req | output | 1 | Program request to the fuse sequencer |

## Verification
A START arriving in the middle of a byte collides with the bit counter that is sampling that byte. In the same synchronised cycle, the receive logic could shift or count while the start detector clears everything. The bench provokes this by driving four data bits and then issuing a repeated START. It judges the outcome by requiring the following full write to be acknowledged and to yield exactly one strobe carrying the new byte. A second collision is the master's NACK and the slave's preload of the next byte on the same SCL fall. This is judged by checking that SDA stays released for many clocks after the NACK.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } cmd_state_e;

    // fields of an accepted instruction that the wiper side consumes
    typedef struct packed {
        logic chan;
        logic shdn;
        logic prog;
        logic ovr;
    } cmd_fields_t;

    localparam logic [4:0] ADDR_PREFIX = 5'b01011;

    // instruction bit positions (wire order, MSB first)
    localparam int IB_CHAN = 7;
    localparam int IB_SHDN = 6;
    localparam int IB_PROG = 5;
    localparam int IB_RSVD = 4;
    localparam int IB_OVR  = 3;

endpackage

// File: rtl/potcmd_bus_sync.sv
module potcmd_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/potcmd_instr_latch.sv
module potcmd_instr_latch
    import potcmd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  cmd_fields_t       fields_in,
    input  logic              data_done,
    input  logic [BYTE_W-1:0] data_in,
    output logic              sel_chan,
    output logic              wr_stb,
    output logic              wr_chan,
    output logic              wr_shdn,
    output logic              wr_ovr,
    output logic              prog_req,
    output logic [BYTE_W-1:0] wr_code
);

    cmd_fields_t held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held     <= '0;
            wr_stb   <= 1'b0;
            prog_req <= 1'b0;
            wr_code  <= '0;
        end else begin
            wr_stb   <= data_done;
            prog_req <= data_done & held.prog;
            if (load)      held    <= fields_in;
            if (data_done) wr_code <= data_in;
        end
    end

    assign sel_chan = held.chan;
    assign wr_chan  = held.chan;
    assign wr_shdn  = held.shdn;
    assign wr_ovr   = held.ovr;

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6
    prog_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> wr_stb);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_chan));

endmodule

// File: rtl/potcmd_i2c_slave.sv
module potcmd_i2c_slave
    import potcmd_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit USE_PINS    = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [1:0]             addr_pins,
    input  logic [1:0][BYTE_W-1:0] chan_codes,
    input  logic [1:0]             valid_bits,
    output logic                   wr_stb,
    output logic                   wr_chan,
    output logic                   wr_shdn,
    output logic                   wr_ovr,
    output logic [BYTE_W-1:0]      wr_code,
    output logic                   prog_req
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    potcmd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cmd_state_e        st, nxt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              tx_stat;
    logic              m_nack;
    logic              sel_chan;
    logic              instr_ld;
    logic              data_done;
    logic [1:0]        low_bits;
    logic              byte_full;
    logic              addr_hit;
    logic [BYTE_W-1:0] status_byte;
    cmd_fields_t       new_fields;

    assign low_bits    = USE_PINS ? addr_pins : 2'b11;
    assign byte_full   = (bit_cnt == CNT_FULL);
    assign addr_hit    = (rx_sh[BYTE_W-1:1] == {ADDR_PREFIX, low_bits});
    assign status_byte = {valid_bits, {(BYTE_W-2){1'b0}}};
    assign new_fields  = '{chan: rx_sh[IB_CHAN], shdn: rx_sh[IB_SHDN],
                           prog: rx_sh[IB_PROG], ovr:  rx_sh[IB_OVR]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_full)
                                  nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) nxt = rx_sh[0] ? ST_TX : ST_INSTR;
                ST_INSTR:     if (scl_fall && byte_full)
                                  nxt = rx_sh[IB_RSVD] ? ST_SKIP : ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:      if (scl_fall && byte_full) nxt = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_TX:        if (scl_fall && bit_cnt == CNT_LAST) nxt = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) nxt = m_nack ? ST_SKIP : ST_TX;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs of the machine
    always_comb begin
        sda_oe    = 1'b0;
        instr_ld  = 1'b0;
        data_done = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:    sda_oe = ~tx_sh[BYTE_W-1];
            ST_INSTR: instr_ld  = (nxt == ST_INSTR_ACK);
            ST_DATA:  data_done = (nxt == ST_DATA_ACK);
            default:  sda_oe = 1'b0;
        endcase
    end

    // shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            tx_sh   <= '1;
            bit_cnt <= '0;
            tx_stat <= 1'b0;
            m_nack  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            tx_sh   <= '1;
        end else begin
            unique case (st)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    tx_sh   <= chan_codes[sel_chan];
                    tx_stat <= 1'b0;
                end
                ST_TX: if (scl_fall) begin
                    tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                    bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
                end
                ST_TX_ACK: begin
                    if (scl_rise) m_nack <= sda_s;
                    if (scl_fall) begin
                        tx_stat <= ~tx_stat;
                        tx_sh   <= tx_stat ? chan_codes[sel_chan] : status_byte;
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    potcmd_instr_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (instr_ld),
        .fields_in (new_fields),
        .data_done (data_done),
        .data_in   (rx_sh),
        .sel_chan  (sel_chan),
        .wr_stb    (wr_stb),
        .wr_chan   (wr_chan),
        .wr_shdn   (wr_shdn),
        .wr_ovr    (wr_ovr),
        .prog_req  (prog_req),
        .wr_code   (wr_code)
    );

    // R11
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R11
    release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4
    rsvd_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ld |-> !rx_sh[IB_RSVD]);

endmodule

// File: tb/potcmd_i2c_slave_tb.sv
module potcmd_i2c_slave_tb;

    localparam int Q  = 4;
    localparam int WD = 180000;
    localparam logic [6:0] ADDR_MAIN = 7'h2E;
    localparam logic [6:0] ADDR_FIX  = 7'h2F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe_a, oe_b;
    wire  sda_bus = sda_m & ~oe_a & ~oe_b;

    logic [1:0][7:0] codes;
    logic [1:0]      vbits;

    logic wr_stb, wr_chan, wr_shdn, wr_ovr, prog_req;
    logic [7:0] wr_code;
    logic f_stb, f_chan, f_shdn, f_ovr, f_prog;
    logic [7:0] f_code;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    int prog_cnt = 0;
    int r11_viol = 0;
    logic [7:0] l_code;
    logic l_chan, l_shdn, l_ovr;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    potcmd_i2c_slave #(.USE_PINS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_a),
        .addr_pins(2'b10), .chan_codes(codes), .valid_bits(vbits),
        .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_shdn(wr_shdn), .wr_ovr(wr_ovr),
        .wr_code(wr_code), .prog_req(prog_req)
    );

    potcmd_i2c_slave #(.USE_PINS(1'b0)) u_fix (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_b),
        .addr_pins(2'b00), .chan_codes(codes), .valid_bits(vbits),
        .wr_stb(f_stb), .wr_chan(f_chan), .wr_shdn(f_shdn), .wr_ovr(f_ovr),
        .wr_code(f_code), .prog_req(f_prog)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            l_code = wr_code;
            l_chan = wr_chan;
            l_shdn = wr_shdn;
            l_ovr  = wr_ovr;
            if (prog_req) prog_cnt++;
        end
        if (rst_n && oe_a != oe_prev && scl_m) r11_viol++;
        oe_prev = oe_a;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack_a, output bit ack_b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack_a = oe_a;
        ack_b = oe_b;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            d[i] = sda_bus;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        put_bit(!mack);
        sda_m = 1'b1;
    endtask

    initial begin
        tick(WD);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WD, 0);
            report();
        end
    end

    initial begin
        bit aa, ab;
        logic [7:0] d;
        int base;
        codes = '{8'hA5, 8'h3C};
        vbits = 2'b10;
        tick(5);
        // R12 reset state
        chk("R12 sda released", oe_a, 0);
        chk("R12 no strobe", wr_stb, 0);
        chk("R12 no request", prog_req, 0);
        rst_n = 1'b1;
        tick(5);

        // R12 / R8: selection after reset is channel 0
        i2c_start();
        send_byte({ADDR_MAIN, 1'b1}, aa, ab);
        read_byte(1'b0, d);
        i2c_stop();
        chk("R12 R8 reset selection reads channel 0", d, 8'h3C);

        // R1 / R2: address sweep, both variants on one bus
        for (int a = 0; a < 128; a++) begin
            i2c_start();
            send_byte({7'(a), 1'b0}, aa, ab);
            chk("R1 pin-address ack", aa, (a == ADDR_MAIN) ? 1 : 0);
            chk("R1 fixed-address ack", ab, (a == ADDR_FIX) ? 1 : 0);
            send_byte(8'h00, aa, ab);
            if (a != ADDR_MAIN) chk("R2 ignored after mismatch", aa, 0);
            if (a != ADDR_FIX)  chk("R2 ignored after mismatch (fixed)", ab, 0);
            i2c_stop();
        end
        chk("R2 no strobe from address sweep", stb_cnt, 0);

        // R3 / R5: one instruction, all 256 data codes
        i2c_start();
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        send_byte(8'hCD, aa, ab); // chan 1, shdn 1, prog 0, rsvd 0, ovr 1, spare 101
        chk("R3 instruction acked", aa, 1);
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), aa, ab);
            tick(2);
            chk("R5 data byte acked", aa, 1);
            chk("R5 strobe count", stb_cnt, v + 1);
            chk("R5 strobe code", l_code, v);
            chk("R3 fields chan/shdn/ovr", {l_chan, l_shdn, l_ovr}, 3'b111);
        end
        i2c_stop();
        chk("R6 no request without program bit", prog_cnt, 0);

        // R6 / R3: program bit set, channel 0, shutdown and overwrite clear
        base = stb_cnt;
        i2c_start();
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        send_byte(8'h20, aa, ab);
        send_byte(8'h5A, aa, ab);
        send_byte(8'h5B, aa, ab);
        tick(2);
        i2c_stop();
        chk("R6 request per data byte", prog_cnt, 2);
        chk("R5 two strobes", stb_cnt - base, 2);
        chk("R3 fields cleared", {l_chan, l_shdn, l_ovr}, 3'b000);
        chk("R5 last code", l_code, 8'h5B);

        // R4: reserved bit set
        base = stb_cnt;
        i2c_start();
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        send_byte(8'h90, aa, ab);
        chk("R4 reserved instruction not acked", aa, 0);
        send_byte(8'h11, aa, ab);
        chk("R4 following byte not acked", aa, 0);
        tick(2);
        i2c_stop();
        chk("R4 no strobe", stb_cnt, base);

        // R7 / R8 / R9: read sweep over validation bits and channel
        for (int v = 0; v < 4; v++) begin
            vbits = 2'(v);
            base = stb_cnt;
            i2c_start();
            send_byte({ADDR_MAIN, 1'b0}, aa, ab);
            send_byte({v[0], 7'b0000000}, aa, ab); // select without data
            i2c_stop();
            chk("R8 select without data: no strobe", stb_cnt, base);
            i2c_start();
            send_byte({ADDR_MAIN, 1'b1}, aa, ab);
            chk("R1 read address acked", aa, 1);
            read_byte(1'b1, d);
            chk("R7 R8 code byte", d, codes[v[0]]);
            read_byte(1'b1, d);
            chk("R7 status byte", d, {2'(v), 6'b000000});
            read_byte(1'b0, d);
            chk("R7 repeated code byte", d, codes[v[0]]);
            begin
                int held = 0;
                for (int k = 0; k < 24; k++) begin
                    if (oe_a) held++;
                    tick(1);
                end
                chk("R9 released after master NACK", held, 0);
            end
            i2c_stop();
        end

        // R10: START in the middle of a data byte
        base = stb_cnt;
        i2c_start();
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        send_byte(8'h00, aa, ab);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        i2c_start();
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        chk("R10 address after mid-byte START acked", aa, 1);
        send_byte(8'h00, aa, ab);
        send_byte(8'h77, aa, ab);
        tick(2);
        chk("R10 exactly one strobe", stb_cnt - base, 1);
        chk("R10 strobe code", l_code, 8'h77);
        i2c_stop();

        // R10: after STOP nothing is acked before a START
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
        send_byte({ADDR_MAIN, 1'b0}, aa, ab);
        chk("R10 no ack after STOP without START", aa, 0);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b1;
        tick(4 * Q);

        chk("R11 drive changes only with SCL low", r11_viol, 0);
        done = 1'b1;
        report();
    end

endmodule